// File: doc/BRIEF.md
# Serial Receiver with Three-Sample Bit Voting

This block receives asynchronous serial characters on a single line that idles high. A character is a low start bit, a configurable number of data bits sent least significant bit first, an optional parity bit, and a high stop bit. A programmable divider derives a tick at sixteen times the bit rate. For example, a 14.7456 MHz clock with a divider setting of 15 gives 57,600 bit/s. The line passes through a two-flop synchronizer before it is sampled.

Each bit is sampled at three consecutive ticks around its middle: ticks 7, 8 and 9 of the sixteen ticks in the bit. The start and stop bits are sampled the same way. The bit value is the majority of the three samples. If the three samples of any bit in a character are not all equal, a noise flag is raised for that character. The noise flag does not change the value that the majority vote picked.

A one-cycle strobe delivers each character together with its noise, framing and parity flags. The data and flag outputs keep their values until the next strobe.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_data_o` and all three error flags are 0. No strobe occurs while the line stays high.
- R2: A character is a start bit, then DATA_BITS data bits sent LSB first, then an optional parity bit, then a stop bit. Each character produces exactly one `rx_valid_o` pulse, one cycle wide, and the received byte is on `rx_data_o` during that pulse.
- R3: The value of a bit is the majority of its samples at oversampling ticks 7, 8 and 9. A disturbance that affects only one of these three samples does not change the received value.
- R4: `rx_noise_o` is 1 with the strobe when any bit of that character had disagreeing samples. This includes the start bit and the stop bit.
- R5: A falling edge on an idle line starts start-bit detection. If the start bit votes high, the receiver returns to idle and no strobe is produced.
- R6: A stop bit that votes low sets `rx_frame_err_o`. The byte is still delivered with the strobe.
- R7: When `par_en_i`=1, a parity bit follows the data. With `par_odd_i`=0 the data bits and the parity bit together must contain an even number of ones; with `par_odd_i`=1 they must contain an odd number. A mismatch sets `rx_parity_err_o`. When `par_en_i`=0 there is no parity bit and `rx_parity_err_o` is 0.
- R8: The oversampling tick occurs once every `baud_div_i`+1 clocks, so one bit lasts 16×(`baud_div_i`+1) clocks.
- R9: A start bit that follows the stop bit directly, with no idle time between them, is received as a new character.
- R10: Between strobes, `rx_data_o` and the three error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, asynchronous, idles high |
| baud_div_i | input | DIV_W | Divider; one oversampling tick per baud_div_i+1 clocks |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| rx_data_o | output | DATA_BITS | Received character |
| rx_valid_o | output | 1 | One-cycle strobe per received character |
| rx_noise_o | output | 1 | Some bit of the character had disagreeing samples |
| rx_frame_err_o | output | 1 | Stop bit voted low |
| rx_parity_err_o | output | 1 | Parity mismatch |

## Verification
A noise verdict and a parity or framing verdict can fall on the same strobe cycle. The noise verdict is gathered bit by bit, while the parity and stop-bit verdicts are formed in the cycle where the stop bit is decided. The bench provokes this with characters that carry a one-tick glitch inside a data bit and also carry a wrong parity bit or a low stop bit. A glitch exactly one tick long overlaps exactly one sample, so the bench knows the expected byte and all three flags without knowing the tick phase. The scoreboard then requires the correct byte and both flags together on that single strobe.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  // receiver sequencing states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } uvr_state_e;

  // oversampling ratio and vote window position
  localparam int unsigned OVS     = 16;
  localparam int unsigned VOTE_N  = 3;
  localparam int unsigned MID_TCK = OVS / 2;

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uvr_tick_gen.sv
module uvr_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign tick_o = (cnt_q >= div_i);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uvr_vote.sv
module uvr_vote #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] smp_i,
  output logic         bit_o,
  output logic         split_o
);

  localparam int unsigned HALF = N / 2;

  logic [$clog2(N+1)-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) begin
      ones = ones + {{($clog2(N+1)-1){1'b0}}, smp_i[i]};
    end
    bit_o   = (ones > HALF[$clog2(N+1)-1:0]);
    split_o = (smp_i != '0) && (smp_i != '1);
  end

endmodule

// File: rtl/uvr_rx_fsm.sv
module uvr_rx_fsm
  import uvr_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 noise_o,
  output logic                 frame_err_o,
  output logic                 parity_err_o
);

  localparam int unsigned PH_W  = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_BITS + 1);
  localparam logic [PH_W-1:0]  PH_FIRST = PH_W'(MID_TCK - 1);
  localparam logic [PH_W-1:0]  PH_MID   = PH_W'(MID_TCK);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(MID_TCK + 1);
  localparam logic [PH_W-1:0]  PH_END   = PH_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(DATA_BITS - 1);

  uvr_state_e           state_q, state_d;
  logic [PH_W-1:0]      ph_q, ph_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [VOTE_N-2:0]    smp_q, smp_d;
  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic                 par_bit_q, par_bit_d;
  logic                 noise_acc_q, noise_acc_d;
  logic                 line_hi_q, line_hi_d;
  logic                 pen_q, pen_d;
  logic                 podd_q, podd_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 nerr_q, nerr_d;
  logic                 ferr_q, ferr_d;
  logic                 perr_q, perr_d;

  logic vote_bit;
  logic vote_split;

  uvr_vote #(.N(VOTE_N)) vote_i (
    .smp_i   ({smp_q, rx_i}),
    .bit_o   (vote_bit),
    .split_o (vote_split)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    ph_d        = ph_q;
    idx_d       = idx_q;
    smp_d       = smp_q;
    shreg_d     = shreg_q;
    par_bit_d   = par_bit_q;
    noise_acc_d = noise_acc_q;
    line_hi_d   = line_hi_q;
    pen_d       = pen_q;
    podd_d      = podd_q;
    data_d      = data_q;
    valid_d     = 1'b0;
    nerr_d      = nerr_q;
    ferr_d      = ferr_q;
    perr_d      = perr_q;

    if (tick_i) begin
      if (state_q == ST_IDLE) begin
        if (rx_i) begin
          line_hi_d = 1'b1;
        end else if (line_hi_q) begin
          state_d     = ST_START;
          ph_d        = '0;
          noise_acc_d = 1'b0;
          line_hi_d   = 1'b0;
          pen_d       = par_en_i;
          podd_d      = par_odd_i;
        end
      end else begin
        ph_d = (ph_q == PH_END) ? '0 : ph_q + 1'b1;

        if ((ph_q == PH_FIRST) || (ph_q == PH_MID)) begin
          smp_d = {smp_q[VOTE_N-3:0], rx_i};
        end

        if (ph_q == PH_LAST) begin
          noise_acc_d = noise_acc_q | vote_split;
          case (state_q)
            ST_START: begin
              if (vote_bit) begin
                state_d   = ST_IDLE;
                ph_d      = '0;
                line_hi_d = 1'b1;
              end
            end
            ST_DATA: shreg_d = {vote_bit, shreg_q[DATA_BITS-1:1]};
            ST_PAR:  par_bit_d = vote_bit;
            ST_STOP: begin
              state_d   = ST_IDLE;
              ph_d      = '0;
              line_hi_d = vote_bit;
              valid_d   = 1'b1;
              data_d    = shreg_q;
              nerr_d    = noise_acc_q | vote_split;
              ferr_d    = ~vote_bit;
              perr_d    = pen_q & ((^shreg_q) ^ par_bit_q ^ podd_q);
            end
            default: ;
          endcase
        end

        if (ph_q == PH_END) begin
          case (state_q)
            ST_START: begin
              state_d = ST_DATA;
              idx_d   = '0;
            end
            ST_DATA: begin
              if (idx_q == IDX_END) state_d = pen_q ? ST_PAR : ST_STOP;
              else                  idx_d   = idx_q + 1'b1;
            end
            ST_PAR:  state_d = ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ph_q        <= '0;
      idx_q       <= '0;
      smp_q       <= '1;
      shreg_q     <= '0;
      par_bit_q   <= 1'b0;
      noise_acc_q <= 1'b0;
      line_hi_q   <= 1'b0;
      pen_q       <= 1'b0;
      podd_q      <= 1'b0;
      data_q      <= '0;
      valid_q     <= 1'b0;
      nerr_q      <= 1'b0;
      ferr_q      <= 1'b0;
      perr_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      ph_q        <= ph_d;
      idx_q       <= idx_d;
      smp_q       <= smp_d;
      shreg_q     <= shreg_d;
      par_bit_q   <= par_bit_d;
      noise_acc_q <= noise_acc_d;
      line_hi_q   <= line_hi_d;
      pen_q       <= pen_d;
      podd_q      <= podd_d;
      data_q      <= data_d;
      valid_q     <= valid_d;
      nerr_q      <= nerr_d;
      ferr_q      <= ferr_d;
      perr_q      <= perr_d;
    end
  end

  assign data_o       = data_q;
  assign valid_o      = valid_q;
  assign noise_o      = nerr_q;
  assign frame_err_o  = ferr_q;
  assign parity_err_o = perr_q;

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  input  logic [DIV_W-1:0]     baud_div_i,
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 rx_noise_o,
  output logic                 rx_frame_err_o,
  output logic                 rx_parity_err_o
);

  logic rx_sync;
  logic baud_tick;

  uvr_sync #(.STAGES(SYNC_LEN)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  uvr_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (baud_div_i),
    .tick_o (baud_tick)
  );

  uvr_rx_fsm #(.DATA_BITS(DATA_BITS)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (baud_tick),
    .rx_i         (rx_sync),
    .par_en_i     (par_en_i),
    .par_odd_i    (par_odd_i),
    .data_o       (rx_data_o),
    .valid_o      (rx_valid_o),
    .noise_o      (rx_noise_o),
    .frame_err_o  (rx_frame_err_o),
    .parity_err_o (rx_parity_err_o)
  );

endmodule

// File: rtl/uvr_rx_chk.sv
module uvr_rx_chk #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [DIV_W-1:0]     div,
  input logic                 par_en,
  input logic [DATA_BITS-1:0] data,
  input logic                 valid,
  input logic                 noise,
  input logic                 ferr,
  input logic                 perr
);

  logic [DIV_W:0]   gap_q;
  logic [DIV_W-1:0] div_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      div_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      div_q <= div;
      if (tick) gap_q <= {{DIV_W{1'b0}}, 1'b1};
      else      gap_q <= gap_q + 1'b1;
      if (div != div_q) armed_q <= 1'b0;
      else if (tick)    armed_q <= 1'b1;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);                                                   // R2

  AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(data) && $stable(noise) && $stable(ferr) && $stable(perr))); // R10

  AST_NO_PARITY_ERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !par_en) |-> !perr);                                       // R7

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed_q && (div == div_q)) |-> (gap_q == ({1'b0, div} + 1'b1))); // R8

endmodule

bind uart_vote_rx uvr_rx_chk #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (baud_tick),
  .div    (baud_div_i),
  .par_en (par_en_i),
  .data   (rx_data_o),
  .valid  (rx_valid_o),
  .noise  (rx_noise_o),
  .ferr   (rx_frame_err_o),
  .perr   (rx_parity_err_o)
);

// File: tb/uart_vote_rx_tb_top.sv
module uart_vote_rx_tb_top;

  localparam int unsigned DIV_W = 16;
  localparam int unsigned DW    = 8;
  localparam int unsigned WDOG  = 150000;

  logic          clk;
  logic          rst_n;
  logic          rx;
  logic [DIV_W-1:0] div;
  logic          par_en;
  logic          par_odd;
  logic [DW-1:0] data;
  logic          valid;
  logic          noise;
  logic          ferr;
  logic          perr;

  int checks;
  int failures;
  int cycles;
  bit done;

  logic [DW+2:0] exp_q[$];
  string         tag_q[$];

  uart_vote_rx #(.DIV_W(DIV_W), .DATA_BITS(DW)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_i            (rx),
    .baud_div_i      (div),
    .par_en_i        (par_en),
    .par_odd_i       (par_odd),
    .rx_data_o       (data),
    .rx_valid_o      (valid),
    .rx_noise_o      (noise),
    .rx_frame_err_o  (ferr),
    .rx_parity_err_o (perr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG);
      finish_run();
    end
  end

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected strobe", {21'd0, data, noise, ferr, perr}, 32'd0);
      end else begin
        logic [DW+2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({data, noise, ferr, perr} == e, t, {21'd0, data, noise, ferr, perr}, {21'd0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bit_clks();
    return 16 * (int'(div) + 1);
  endfunction

  // glitch: inverts the line for exactly one tick period starting at 68 clocks into the bit
  task automatic drive_bit(input logic v, input bit glitch);
    int bc;
    bc = bit_clks();
    rx = v;
    if (glitch) begin
      wait_clk(68);
      rx = ~v;
      wait_clk(int'(div) + 1);
      rx = v;
      wait_clk(bc - 68 - (int'(div) + 1));
    end else begin
      wait_clk(bc);
    end
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input bit pen, input bit podd,
                            input bit bad_par, input bit bad_stop, input int glitch_at,
                            input string tag);
    logic pbit;
    int   pos;
    par_en  = pen;
    par_odd = podd;
    pbit = (podd ? ~(^d) : (^d)) ^ bad_par;
    exp_q.push_back({d, glitch_at >= 0, bad_stop, pen & bad_par});
    tag_q.push_back(tag);
    pos = 0;
    drive_bit(1'b0, glitch_at == pos);
    pos++;
    for (int i = 0; i < DW; i++) begin
      drive_bit(d[i], glitch_at == pos);
      pos++;
    end
    if (pen) begin
      drive_bit(pbit, glitch_at == pos);
      pos++;
    end
    drive_bit(~bad_stop, glitch_at == pos);
    rx = 1'b1;
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0; done = 1'b0;
    rx = 1'b1; div = 16'd7; par_en = 1'b0; par_odd = 1'b0;
    rst_n = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(300);

    // R1: reset state with idle line
    check(valid == 1'b0, "R1 valid", {31'd0, valid}, 32'd0);
    check(data == '0,    "R1 data",  {24'd0, data}, 32'd0);
    check(noise == 1'b0, "R1 noise", {31'd0, noise}, 32'd0);
    check(ferr == 1'b0,  "R1 frame", {31'd0, ferr}, 32'd0);
    check(perr == 1'b0,  "R1 parity", {31'd0, perr}, 32'd0);

    // R2 R8: clean character, no parity
    send_frame(8'hA5, 0, 0, 0, 0, -1, "R2 clean no parity");
    wait_clk(bit_clks());
    // R7: even and odd parity, correct
    send_frame(8'h3C, 1, 0, 0, 0, -1, "R7 even parity ok");
    wait_clk(bit_clks());
    send_frame(8'h3C, 1, 1, 0, 0, -1, "R7 odd parity ok");
    wait_clk(bit_clks());
    // R7: wrong parity
    send_frame(8'h81, 1, 0, 1, 0, -1, "R7 even parity bad");
    wait_clk(bit_clks());
    // R3 R4: one-sample glitch in data bit 3 (position 4)
    send_frame(8'h5A, 0, 0, 0, 0, 4, "R3 R4 glitch data bit");
    wait_clk(bit_clks());
    // R4: glitch in start bit
    send_frame(8'hF0, 0, 0, 0, 0, 0, "R4 glitch start bit");
    wait_clk(bit_clks());
    // R4: glitch in stop bit (no parity: position 9)
    send_frame(8'h0F, 0, 0, 0, 0, 9, "R4 glitch stop bit");
    wait_clk(bit_clks());
    // R6: low stop bit
    send_frame(8'h66, 0, 0, 0, 1, -1, "R6 framing error");
    wait_clk(2 * bit_clks());
    // R10: outputs held between strobes
    check(data == 8'h66 && ferr == 1'b1, "R10 hold", {23'd0, data, ferr}, {23'd0, 8'h66, 1'b1});

    // R5: false start, line low for three ticks only
    rx = 1'b0;
    wait_clk(3 * (int'(div) + 1));
    rx = 1'b1;
    wait_clk(2 * bit_clks());
    check(exp_q.size() == 0, "R5 false start", exp_q.size(), 32'd0);
    send_frame(8'h99, 0, 0, 0, 0, -1, "R5 after false start");
    wait_clk(bit_clks());

    // noise together with parity error, and with framing error
    send_frame(8'hC3, 1, 1, 1, 0, 6, "R4 R7 noise and parity");
    wait_clk(bit_clks());
    send_frame(8'h11, 0, 0, 0, 1, 3, "R4 R6 noise and framing");
    wait_clk(2 * bit_clks());

    // R9: back to back characters
    send_frame(8'h12, 1, 0, 0, 0, -1, "R9 first");
    send_frame(8'h34, 1, 0, 0, 0, -1, "R9 second");
    wait_clk(bit_clks());

    // R8: faster divider
    div = 16'd3;
    wait_clk(200);
    send_frame(8'h55, 0, 0, 0, 0, -1, "R8 divider 3 first");
    wait_clk(bit_clks());
    send_frame(8'hAA, 1, 1, 0, 0, -1, "R8 divider 3 second");
    wait_clk(2 * bit_clks());

    check(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule